// File: doc/BRIEF.md
# Spline Evolution Tick Divider

This block sets the pace at which all spline interpolators of one waveform channel step forward. It holds a programmable divide ratio and a running counter, and emits one enable strobe that every interpolator in the channel shares, so they all advance on the same cycle. With a divide value of `d`, the strobe fires once every `d+1` coarse clock cycles; `d = 0` makes it fire on every cycle.

Software reaches the block through a timed command channel. A single configuration word at the divider address loads two fields together: the divide value and a preset for the running counter. Loading the counter lets several channels be brought into a known phase of their update cadence, or lets one channel be shifted mid-count. The oscillator phase accumulators are not touched by this strobe; they step on every cycle regardless.

The counter counts up from its preset. When it equals the divide value the strobe is high for that cycle and the counter returns to zero on the next. A preset above the divide value produces no strobe; the counter drops to zero one cycle later and then counts normally.

Top module: `spline_tick_div`

## Requirements
- R1: After reset the divide value and the counter are both 0, so `tick` is high on every cycle until the first divider write.
- R2: A write is `cfg_valid` high with `cfg_addr` equal to 0. It loads the divide value from `cfg_data[15:0]` and the counter preset from `cfg_data[31:16]`, both taking effect at the clock edge that samples the write.
- R3: With divide value `d` and no further writes, consecutive `tick` pulses are exactly `d+1` cycles apart.
- R4: After a write whose preset `n` is at most `d`, the first `tick` comes `d-n` cycles after the first cycle following the write, so `n = d` gives a `tick` in that first cycle.
- R5: After a write whose preset `n` exceeds `d`, `tick` stays low in the first cycle, the counter wraps to 0 on the next cycle, and the first `tick` comes `d+1` cycles after the first cycle following the write.
- R6: A write with any other `cfg_addr`, or with `cfg_valid` low, changes neither the divide value nor the counter, so the `tick` schedule continues unchanged.
- R7: With a nonzero divide value and no write, `tick` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Coarse system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word present this cycle |
| cfg_addr | input | 4 | Configuration register address; 0 selects the divider |
| cfg_data | input | 32 | Configuration word: divide value in [15:0], counter preset in [31:16] |
| tick | output | 1 | Shared interpolator advance strobe |

## Verification
The strobe is a function of the registered divide value and counter, so a write sampled at one rising edge shows its first effect in the cycle that edge opens, and each later `tick` falls at a fixed count of edges after it. The bench keeps a cycle index since the last divider write, drives inputs and samples `tick` only at falling edges, and derives the expected strobe for that index from the written divide value and preset with a closed-form rule. Every cycle of every directed and random sequence is compared this way, including the preset-above-divider case, mid-count reloads and writes to other addresses that must leave the index running.

// File: rtl/spline_tick_div_pkg.sv
package spline_tick_div_pkg;

   // How the shared strobe is produced.
   //  STROBE_COMB : compare of the current counter and divide value.
   //  STROBE_REG  : flop fed by a prediction of the next-cycle compare.
   typedef enum logic {
      STROBE_COMB = 1'b0,
      STROBE_REG  = 1'b1
   } strobe_mode_e;

   localparam int unsigned DEF_TICK_W = 16;
   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_ADDR_W = 4;

endpackage

// File: rtl/stdiv_cfg_decode.sv
module stdiv_cfg_decode #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned TICK_W   = 16,
   parameter int unsigned DIV_LSB  = 0,
   parameter int unsigned PRE_LSB  = 16,
   parameter logic [ADDR_W-1:0] SEL_ADDR = '0
) (
   input  logic              cfg_valid_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_data_i,
   output logic              load_o,
   output logic [TICK_W-1:0] div_val_o,
   output logic [TICK_W-1:0] pre_val_o
);

   localparam int unsigned DIV_MSB = DIV_LSB + TICK_W - 1;
   localparam int unsigned PRE_MSB = PRE_LSB + TICK_W - 1;

   if (DIV_MSB >= DATA_W) begin : g_bad_div_field
      $error("divide field does not fit in the configuration word");
   end
   if (PRE_MSB >= DATA_W) begin : g_bad_pre_field
      $error("preset field does not fit in the configuration word");
   end

   assign load_o    = cfg_valid_i && (cfg_addr_i == SEL_ADDR);
   assign div_val_o = cfg_data_i[DIV_LSB +: TICK_W];
   assign pre_val_o = cfg_data_i[PRE_LSB +: TICK_W];

endmodule

// File: rtl/stdiv_div_reg.sv
module stdiv_div_reg #(
   parameter int unsigned TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [TICK_W-1:0] div_i,
   output logic [TICK_W-1:0] div_q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q_o <= '0;
      end else if (load_i) begin
         div_q_o <= div_i;
      end
   end

endmodule

// File: rtl/stdiv_counter.sv
module stdiv_counter #(
   parameter int unsigned TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [TICK_W-1:0] pre_i,
   input  logic [TICK_W-1:0] div_q_i,
   output logic [TICK_W-1:0] cnt_q_o
);

   localparam logic [TICK_W-1:0] ONE = {{(TICK_W-1){1'b0}}, 1'b1};

   logic [TICK_W-1:0] cnt_nxt;

   // Reload wins; otherwise count up and fall back to zero once the
   // counter has reached (or was preset past) the divide value.
   always_comb begin
      if (load_i) begin
         cnt_nxt = pre_i;
      end else if (cnt_q_o >= div_q_i) begin
         cnt_nxt = '0;
      end else begin
         cnt_nxt = cnt_q_o + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q_o <= '0;
      end else begin
         cnt_q_o <= cnt_nxt;
      end
   end

endmodule

// File: rtl/spline_tick_div.sv
module spline_tick_div
   import spline_tick_div_pkg::*;
#(
   parameter int unsigned  ADDR_W   = DEF_ADDR_W,
   parameter int unsigned  DATA_W   = DEF_DATA_W,
   parameter int unsigned  TICK_W   = DEF_TICK_W,
   parameter int unsigned  DIV_LSB  = 0,
   parameter int unsigned  PRE_LSB  = 16,
   parameter logic [ADDR_W-1:0] DIV_ADDR = '0,
   parameter strobe_mode_e STROBE_MODE = STROBE_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   output logic              tick
);

   localparam int unsigned FIELD_SPAN = 2 * TICK_W;
   localparam logic [TICK_W-1:0] ONE = {{(TICK_W-1){1'b0}}, 1'b1};

   if (TICK_W < 1) begin : g_bad_width
      $error("TICK_W must be at least 1");
   end
   if (DATA_W < FIELD_SPAN) begin : g_bad_data_w
      $error("configuration word too narrow for both fields");
   end
   if ((DIV_LSB < PRE_LSB + TICK_W) && (PRE_LSB < DIV_LSB + TICK_W)) begin : g_bad_overlap
      $error("divide and preset fields overlap");
   end

   logic              cfg_load;
   logic [TICK_W-1:0] cfg_div;
   logic [TICK_W-1:0] cfg_pre;
   logic [TICK_W-1:0] div_q;
   logic [TICK_W-1:0] cnt_q;

   stdiv_cfg_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .TICK_W   (TICK_W),
      .DIV_LSB  (DIV_LSB),
      .PRE_LSB  (PRE_LSB),
      .SEL_ADDR (DIV_ADDR)
   ) u_decode (
      .cfg_valid_i (cfg_valid),
      .cfg_addr_i  (cfg_addr),
      .cfg_data_i  (cfg_data),
      .load_o      (cfg_load),
      .div_val_o   (cfg_div),
      .pre_val_o   (cfg_pre)
   );

   stdiv_div_reg #(
      .TICK_W (TICK_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (cfg_load),
      .div_i   (cfg_div),
      .div_q_o (div_q)
   );

   stdiv_counter #(
      .TICK_W (TICK_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (cfg_load),
      .pre_i   (cfg_pre),
      .div_q_i (div_q),
      .cnt_q_o (cnt_q)
   );

   if (STROBE_MODE == STROBE_REG) begin : g_strobe_reg
      // Predict next cycle's equality from the current state so the
      // strobe leaves a flop with the same cycle timing as the compare.
      logic tick_q;
      logic tick_pred;

      always_comb begin
         if (cfg_load) begin
            tick_pred = (cfg_pre == cfg_div);
         end else if (cnt_q >= div_q) begin
            tick_pred = (div_q == '0);
         end else begin
            tick_pred = ((cnt_q + ONE) == div_q);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tick_q <= 1'b1;
         end else begin
            tick_q <= tick_pred;
         end
      end

      assign tick = tick_q;
   end else begin : g_strobe_comb
      assign tick = (cnt_q == div_q);
   end

endmodule

// File: rtl/spline_tick_div_chk.sv
module spline_tick_div_chk #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned TICK_W  = 16,
   parameter int unsigned DIV_LSB = 0,
   parameter int unsigned PRE_LSB = 16,
   parameter logic [ADDR_W-1:0] DIV_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_valid,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_data,
   input logic              tick,
   input logic [TICK_W-1:0] div_q,
   input logic [TICK_W-1:0] cnt_q
);

   logic wr;
   logic seen_wr;
   logic [TICK_W-1:0] wr_div;
   logic [TICK_W-1:0] wr_pre;

   assign wr     = cfg_valid && (cfg_addr == DIV_ADDR);
   assign wr_div = cfg_data[DIV_LSB +: TICK_W];
   assign wr_pre = cfg_data[PRE_LSB +: TICK_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_wr <= 1'b0;
      end else if (wr) begin
         seen_wr <= 1'b1;
      end
   end

   a_r1_tick_until_write: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_wr |-> tick);

   a_r2_load_match: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (tick == ($past(wr_pre) == $past(wr_div))));

   a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (cnt_q <= div_q));

   a_r5_no_tick_over: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (wr_pre > wr_div)) |=> !tick);

   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && (cnt_q > div_q)) |=> (cnt_q == '0));

   a_r6_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(div_q));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (div_q != '0) && !wr) |=> !tick);

endmodule

bind spline_tick_div spline_tick_div_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .TICK_W   (TICK_W),
   .DIV_LSB  (DIV_LSB),
   .PRE_LSB  (PRE_LSB),
   .DIV_ADDR (DIV_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_valid (cfg_valid),
   .cfg_addr  (cfg_addr),
   .cfg_data  (cfg_data),
   .tick      (tick),
   .div_q     (div_q),
   .cnt_q     (cnt_q)
);

// File: tb/spline_tick_div_tb.sv
`timescale 1ns/1ps
module spline_tick_div_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_data = '0;
   logic        tick;

   int total = 0;
   int bad   = 0;

   // Bench model: last written divide value, preset, and edges since then.
   int unsigned md = 0;
   int unsigned mn = 0;
   int unsigned mk = 0;

   always #2.5 clk = ~clk;

   spline_tick_div u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_addr  (cfg_addr),
      .cfg_data  (cfg_data),
      .tick      (tick)
   );

   // Closed form from R4/R5: first strobe offset, then period d+1 (R3).
   function automatic logic exp_tick(int unsigned d, int unsigned n, int unsigned k);
      int unsigned off;
      off = (n <= d) ? (d - n) : (d + 1);
      if (k < off) return 1'b0;
      return ((k - off) % (d + 1)) == 0;
   endfunction

   task automatic step(input logic v, input logic [3:0] a, input logic [31:0] dt,
                       input string tag);
      logic e;
      @(negedge clk);
      e = exp_tick(md, mn, mk);
      total++;
      if (tick !== e) begin
         bad++;
         $display("FAIL %s: d=%0d n=%0d k=%0d tick=%b expected=%b",
                  tag, md, mn, mk, tick, e);
      end
      cfg_valid = v;
      cfg_addr  = a;
      cfg_data  = dt;
      @(posedge clk);
      if (v && a == 4'd0) begin
         md = dt[15:0];
         mn = dt[31:16];
         mk = 0;
      end else begin
         mk++;
      end
   endtask

   task automatic idle(input int cycles, input string tag);
      for (int i = 0; i < cycles; i++) step(1'b0, 4'd0, 32'd0, tag);
   endtask

   task automatic load(input int unsigned d, input int unsigned n, input string tag);
      step(1'b1, 4'd0, {n[15:0], d[15:0]}, tag);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      mk = 1;

      // R1: reset state strobes every cycle
      idle(6, "R1");
      // R2/R4: preset equal to divider fires in the first cycle
      load(4, 4, "R2");
      idle(12, "R2");
      // R3/R4: preset 0, divider 3
      load(3, 0, "R4");
      idle(14, "R3");
      // R4: mid-count reload
      idle(1, "R4");
      load(5, 2, "R4");
      idle(15, "R4");
      // R5: preset above divider
      load(2, 9, "R5");
      idle(10, "R5");
      load(0, 5, "R5");
      idle(5, "R5");
      // R6: other address and invalid writes leave schedule running
      load(6, 1, "R6");
      idle(2, "R6");
      step(1'b1, 4'd3, {16'd0, 16'd0}, "R6");
      step(1'b0, 4'd0, {16'd7, 16'd1}, "R6");
      step(1'b1, 4'd15, 32'hFFFF_FFFF, "R6");
      idle(12, "R6");
      // R7: long period, single-cycle pulses
      load(300, 298, "R7");
      idle(620, "R7");
      // Back to full rate
      load(0, 0, "R3");
      idle(5, "R3");

      // Random mix
      for (int it = 0; it < 300; it++) begin
         int unsigned d, n, sel;
         logic [3:0] a;
         d   = $urandom_range(0, 9);
         n   = $urandom_range(0, d + 3);
         sel = $urandom_range(0, 9);
         a   = (sel < 7) ? 4'd0 : 4'($urandom_range(1, 15));
         step(sel != 9, a, {n[15:0], d[15:0]}, (a == 4'd0) ? "R4" : "R6");
         idle($urandom_range(0, 25), "R3");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule